// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front End

This block sits in front of a small on-chip memory array and gives it the cycle behaviour of a synchronous burst SRAM bus. On each rising clock edge it takes in three chip selects, two address strobes, a burst step input, the write qualifiers and the address. From these it classifies the cycle as a deselect, the start of a new access at the external address, a step to the next burst address, or a hold at the current burst address. Each access is a read or a write. Writes go into the array under a byte-lane mask in the same edge.

Read data leaves through one of two paths, picked by a static mode input. The registered path adds an output register and is one edge slower than the direct path. The output drive enable is an explicit signal, and a low value stands for high impedance. After a deselect, the drivers stay on for one full cycle before they turn off. An asynchronous output enable can force the drivers off at any time. The read pipeline, and not the output enable, decides when they may turn on.

The burst counter steps the two low address bits and wraps inside an aligned group of four words. The upper address bits stay fixed for the whole burst.

Top module: `sbsram_fe`

## Requirements
- R1: The device counts as enabled only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A cycle with `strb_ctl_n` low while not enabled is a deselect. It writes nothing and ends the burst, so later cycles with both strobes high access nothing.
- R2: `strb_cpu_n` low with `sel_a_n` low starts a read at `addr`, whatever the write inputs are. With `sel_a_n` high that strobe is ignored and the cycle is decoded as if it were high.
- R3: `strb_ctl_n` low while enabled, with `strb_cpu_n` not taken, starts a read or a write at `addr`.
- R4: With neither strobe taken and a burst open, `step_n`=0 moves to the next address and `step_n`=1 reuses the current one. The next address adds one to bits [1:0] modulo 4 and leaves the upper bits unchanged.
- R5: A cycle is a write when `wr_all_n`=0, which writes all bytes. It is also a write when `wr_byte_n`=0 and some bit of `lane_n` is 0, and then only the bytes whose `lane_n` bit is 0 are written. Bit i of `lane_n` controls `wdata`[8i+7:8i].
- R6: Any cycle that is not a write is a read, and it returns the whole word on every lane.
- R7: `drv_en` is 0 in any cycle whose decoded access is a write.
- R8: With `pipe_sel`=1, read data is driven in the cycle that follows the second rising edge after the read was sampled.
- R9: With `pipe_sel`=0, read data is driven in the cycle that follows the first rising edge after the read was sampled.
- R10: After a deselect, `drv_en` stays 1 for the next cycle if a read preceded it, with that read's data. It is 0 after the second edge, in both modes.
- R11: `oe_n`=1 forces `drv_en` to 0 at once, with no clock edge. `oe_n`=0 only lets through a drive that the read pipeline has marked.
- R12: Reads issued while `oe_n`=1 still step the burst address.
- R13: Synchronous reset leaves `drv_en` at 0 and no burst open, so cycles with both strobes high write nothing. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pipe_sel | input | 1 | 1 = registered read path, 0 = direct read path |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sel_a_n | input | 1 | Chip select, active low, also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, read only |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_n | input | DW/8 | Per-byte write selects, active low |
| addr | input | AW | External word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid while drv_en is 1 |
| drv_en | output | 1 | Output drive enable, 0 means high impedance |

## Verification
The hardest case to reach is the dual-cycle turn-off in the direct path. There, the hold cycle after a deselect shows the data of the read that came before it, not the array word at the deselect address. The stimulus puts a deselect right after a burst step in direct mode and checks both the hold cycle and the cycle after it. Two more cases need an odd mix of inputs at the pins: the ignored processor strobe needs `sel_a_n` high while a burst is open, and the stepping during dummy reads needs `oe_n` held high across several burst steps, then released to show which word the counter has reached.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DESEL,
        OP_RD_NEW,
        OP_WR_NEW,
        OP_RD_NEXT,
        OP_WR_NEXT,
        OP_RD_HOLD,
        OP_WR_HOLD
    } op_e;

    typedef struct packed {
        logic rd;
        logic off;
    } slot_t;

    function automatic logic op_is_rd(op_e o);
        return (o == OP_RD_NEW) || (o == OP_RD_NEXT) || (o == OP_RD_HOLD);
    endfunction

    function automatic logic op_is_wr(op_e o);
        return (o == OP_WR_NEW) || (o == OP_WR_NEXT) || (o == OP_WR_HOLD);
    endfunction

    function automatic logic op_is_off(op_e o);
        return (o == OP_DESEL) || (o == OP_NONE);
    endfunction

endpackage

// File: rtl/sbsram_cmd_decode.sv
module sbsram_cmd_decode
    import sbsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          strb_cpu_n,
    input  logic          strb_ctl_n,
    input  logic          step_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [NB-1:0] lane_n,
    input  logic [AW-1:0] addr,
    output op_e           op,
    output logic [AW-1:0] acc_addr,
    output logic [NB-1:0] wmask
);
    localparam int GB = BURST_BITS;

    logic          live_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] nxt;
    logic          enabled;
    logic          wqual;

    always_comb begin
        enabled = !sel_a_n && sel_b && !sel_c_n;
        wqual   = !wr_all_n || (!wr_byte_n && !(&lane_n));
        nxt     = {base_q[AW-1:GB], base_q[GB-1:0] + GB'(1)};
        op       = OP_NONE;
        acc_addr = base_q;
        if (!strb_cpu_n && !sel_a_n) begin
            op       = enabled ? OP_RD_NEW : OP_DESEL;
            acc_addr = addr;
        end else if (!strb_ctl_n) begin
            op       = !enabled ? OP_DESEL : (wqual ? OP_WR_NEW : OP_RD_NEW);
            acc_addr = addr;
        end else if (live_q) begin
            if (step_n) begin
                op = wqual ? OP_WR_HOLD : OP_RD_HOLD;
            end else begin
                op       = wqual ? OP_WR_NEXT : OP_RD_NEXT;
                acc_addr = nxt;
            end
        end
        if (!op_is_wr(op))  wmask = '0;
        else if (!wr_all_n) wmask = '1;
        else                wmask = ~lane_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            base_q <= '0;
        end else if (op == OP_DESEL) begin
            live_q <= 1'b0;
        end else if (op != OP_NONE) begin
            live_q <= 1'b1;
            base_q <= acc_addr;
        end
    end

    // R4: a step changes only the low burst bits, by one with wrap
    p_step_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_NEXT || op == OP_WR_NEXT) |->
        (acc_addr[GB-1:0] == $past(acc_addr[GB-1:0]) + GB'(1)) &&
        (acc_addr[AW-1:GB] == $past(acc_addr[AW-1:GB])));

    // R4: a hold reuses the previous access address
    p_hold_same_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_HOLD || op == OP_WR_HOLD) |-> acc_addr == $past(acc_addr));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic [NB-1:0]   wmask,
    input  logic [AW-1:0]   waddr,
    input  logic [NB*8-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [NB*8-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wmask[g]) lane_mem[waddr] <= wdata[g*8 +: 8];
        end

        assign rdata[g*8 +: 8] = lane_mem[raddr];
    end

endmodule

// File: rtl/sbsram_rdpath.sv
module sbsram_rdpath
    import sbsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_sel,
    input  logic          oe_n,
    input  logic          cur_rd,
    input  logic          cur_off,
    input  logic          cur_wr,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          drv_en
);
    slot_t         s1_q;
    logic [AW-1:0] s1_addr_q;
    logic          s2_rd_q;
    logic [DW-1:0] s2_data_q;
    logic          marked;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '0;
            s1_addr_q <= '0;
            s2_rd_q   <= 1'b0;
            s2_data_q <= '0;
        end else begin
            s1_q.rd   <= cur_rd;
            s1_q.off  <= cur_off;
            s1_addr_q <= cur_addr;
            s2_rd_q   <= s1_q.rd;
            s2_data_q <= arr_rdata;
        end
    end

    always_comb begin
        raddr = s1_addr_q;
        if (pipe_sel) begin
            marked = s2_rd_q;
            rdata  = s2_data_q;
        end else begin
            marked = s1_q.rd || (s1_q.off && s2_rd_q);
            rdata  = s1_q.rd ? arr_rdata : s2_data_q;
        end
        drv_en = marked && !oe_n && !cur_wr;
    end

    // R11: output enable high keeps the drivers off
    p_oe_gate_r11: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drv_en);

    // R7: no drive while a write is presented
    p_wr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        cur_wr |-> !drv_en);

    // R8: registered path drives only for a read sampled two edges back
    p_pipe_lat_r8: assert property (@(posedge clk) disable iff (rst)
        (pipe_sel && drv_en) |-> $past(cur_rd, 2));

endmodule

// File: rtl/sbsram_fe.sv
module sbsram_fe
    import sbsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pipe_sel,
    input  logic            oe_n,
    input  logic            sel_a_n,
    input  logic            sel_b,
    input  logic            sel_c_n,
    input  logic            strb_cpu_n,
    input  logic            strb_ctl_n,
    input  logic            step_n,
    input  logic            wr_all_n,
    input  logic            wr_byte_n,
    input  logic [DW/8-1:0] lane_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            drv_en
);
    localparam int NB = DW / 8;

    op_e           op;
    logic [AW-1:0] acc_addr;
    logic [NB-1:0] wmask;
    logic [AW-1:0] raddr;
    logic [DW-1:0] arr_rdata;

    sbsram_cmd_decode #(.AW(AW), .NB(NB)) u_dec (
        .clk(clk), .rst(rst),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .addr(addr), .op(op), .acc_addr(acc_addr), .wmask(wmask)
    );

    sbsram_array #(.AW(AW), .NB(NB)) u_arr (
        .clk(clk), .wmask(wmask), .waddr(acc_addr), .wdata(wdata),
        .raddr(raddr), .rdata(arr_rdata)
    );

    sbsram_rdpath #(.AW(AW), .DW(DW)) u_rd (
        .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .oe_n(oe_n),
        .cur_rd(op_is_rd(op)), .cur_off(op_is_off(op)), .cur_wr(op_is_wr(op)),
        .cur_addr(acc_addr), .arr_rdata(arr_rdata),
        .raddr(raddr), .rdata(rdata), .drv_en(drv_en)
    );

    // R1: controller strobe while not enabled never writes
    p_desel_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl_n && (sel_a_n || !sel_b || sel_c_n)) |-> (wmask == '0));

    // R2: a taken processor strobe never writes
    p_cpu_read_r2: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n && !sel_a_n) |-> (wmask == '0));

    // R10: two deselects in a row leave the drivers off afterwards
    p_dcd_off_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DESEL) ##1 (op == OP_DESEL) |=> !drv_en);

endmodule

// File: tb/sbsram_fe_tb.sv
module sbsram_fe_tb;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic clk = 1'b0;
    logic rst, pipe_sel, oe_n;
    logic sel_a_n, sel_b, sel_c_n, strb_cpu_n, strb_ctl_n, step_n;
    logic wr_all_n, wr_byte_n;
    logic [NB-1:0] lane_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic drv_en;

    always #4 clk = ~clk;

    sbsram_fe #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .oe_n(oe_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .drv_en(drv_en)
    );

    typedef struct {
        int          due;
        logic        en;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0, total = 0, bad = 0;
    logic [31:0] shadow [64];
    logic [5:0]  cur;
    logic        live, prev_rd, oe_next, done;
    logic [31:0] last_rd;
    int          lat;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic push(input int due, input logic en, input logic [31:0] d, input string req);
        exp_t e;
        e.due = due; e.en = en; e.data = d; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        #2;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic want;
                want = sb[i].en && !oe_n;
                if (drv_en !== want)
                    check(1'b0, {sb[i].req, " drv_en"}, {31'd0, drv_en}, {31'd0, want});
                else if (want)
                    check(rdata === sb[i].data, {sb[i].req, " rdata"}, rdata, sb[i].data);
                else
                    check(1'b1, sb[i].req, 0, 0);
                sb.delete(i);
            end
        end
    end

    task automatic drive(input logic an, input logic b, input logic cn, input logic cpun,
                         input logic ctln, input logic stn, input logic waln, input logic wbn,
                         input logic [3:0] ln, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_a_n = an; sel_b = b; sel_c_n = cn; strb_cpu_n = cpun; strb_ctl_n = ctln;
        step_n = stn; wr_all_n = waln; wr_byte_n = wbn; lane_n = ln; addr = a; wdata = d;
        oe_n = oe_next;
        cyc++;
    endtask

    task automatic m_read(input logic [5:0] a, input string req);
        push(cyc + lat, 1'b1, shadow[a], req);
        prev_rd = 1'b1; last_rd = shadow[a]; cur = a; live = 1'b1;
    endtask

    task automatic m_write(input logic [5:0] a, input logic [3:0] m, input logic [31:0] d, input string req);
        for (int k = 0; k < 4; k++) if (m[k]) shadow[a][k*8 +: 8] = d[k*8 +: 8];
        for (int i = sb.size() - 1; i >= 0; i--) if (sb[i].due == cyc) sb.delete(i);
        push(cyc, 1'b0, 0, req);
        prev_rd = 1'b0; cur = a; live = 1'b1;
    endtask

    task automatic m_desel();
        if (lat == 2) push(cyc + 2, 1'b0, 0, "R10 pipe off");
        else          push(cyc + 1, prev_rd, last_rd, "R10 direct hold");
        prev_rd = 1'b0; live = 1'b0;
    endtask

    task automatic t_desel();
        drive(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, 0, 0);
        m_desel();
    endtask

    // controller strobe cycle, enables given explicitly
    task automatic t_ctl(input logic [5:0] a, input logic [31:0] d, input logic waln,
                         input logic wbn, input logic [3:0] ln, input string req,
                         input logic an = 0, input logic b = 1, input logic cn = 0);
        logic wq;
        drive(an, b, cn, 1, 0, 1, waln, wbn, ln, a, d);
        wq = !waln || (!wbn && ln != 4'hF);
        if (an || !b || cn) m_desel();
        else if (wq) m_write(a, !waln ? 4'hF : ~ln, d, req);
        else m_read(a, req);
    endtask

    // processor strobe cycle: write inputs set to "write all", which must be ignored
    task automatic t_cpu(input logic [5:0] a, input string req);
        drive(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, a, 32'hBAD0BAD0);
        m_read(a, req);
    endtask

    // both strobes high (or processor strobe ignored through sel_a_n)
    task automatic t_cont(input logic stn, input logic waln, input logic [31:0] d, input string req,
                          input logic cpun = 1, input logic an = 0);
        logic [5:0] a;
        drive(an, 1, 0, cpun, 1, stn, waln, 1, 4'hF, 0, d);
        if (!live) begin
            prev_rd = 1'b0;
        end else begin
            a = stn ? cur : {cur[5:2], cur[1:0] + 2'd1};
            if (!waln) m_write(a, 4'hF, d, req);
            else       m_read(a, req);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        done = 1'b0;
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R13 actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        rst = 1'b1; pipe_sel = 1'b1; oe_next = 1'b0; oe_n = 1'b0;
        sel_a_n = 1; sel_b = 1; sel_c_n = 0; strb_cpu_n = 1; strb_ctl_n = 0; step_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; addr = 0; wdata = 0;
        live = 0; prev_rd = 0; cur = 0; last_rd = 0; lat = 2;
        for (int i = 0; i < 64; i++) shadow[i] = 32'hx;

        repeat (3) t_desel();
        rst = 1'b0;
        t_desel();
        #2 check(drv_en === 1'b0, "R13 reset drive off", {31'd0, drv_en}, 0);

        // R13: reset keeps the array, closes the burst
        t_ctl(0, 32'hC0DE0000, 0, 1, 4'hF, "R3 write");
        t_desel(); t_desel();
        rst = 1'b1;
        t_desel(); t_desel();
        rst = 1'b0;
        live = 0; prev_rd = 0;
        t_cont(0, 0, 32'hDEADDEAD, "R13 idle write");
        t_cont(1, 0, 32'hDEADDEAD, "R13 idle write");
        t_desel();
        t_ctl(0, 0, 1, 1, 4'hF, "R13 array kept");
        t_desel(); t_desel();

        // R3 R4 R5: write burst 4..7, then 10, 12..15
        t_ctl(4, 32'hA0A00004, 0, 1, 4'hF, "R7 write quiet");
        t_cont(0, 0, 32'hA0A00005, "R4 step write");
        t_cont(0, 0, 32'hA0A00006, "R4 step write");
        t_cont(0, 0, 32'hA0A00007, "R4 step write");
        t_ctl(10, 32'h0000000A, 0, 1, 4'hF, "R3 write");
        t_ctl(12, 32'h0C0C0C0C, 0, 1, 4'hF, "R3 write");
        t_cont(0, 0, 32'h0D0D0D0D, "R4 step write");
        t_cont(0, 0, 32'h0E0E0E0E, "R4 step write");
        t_cont(0, 0, 32'h0F0F0F0F, "R4 step write");
        t_desel();

        // R5 byte lanes, R6 read when byte enable is off
        t_ctl(9, 32'h11223344, 0, 1, 4'hF, "R5 write all");
        t_ctl(9, 32'hAABBCCDD, 1, 0, 4'b1010, "R5 byte mask");
        t_desel(); t_desel();
        t_ctl(9, 32'hFFFFFFFF, 1, 1, 4'h0, "R6 R5 lanes 0,2 written");
        t_desel(); t_desel();

        // R2 R8 R4: processor strobe read, steps with wrap, registered path
        t_cpu(5, "R2 R8 read ignores write inputs");
        t_cont(0, 1, 0, "R8 R4 step");
        t_cont(0, 1, 0, "R8 R4 step");
        t_cont(0, 1, 0, "R8 R4 wrap");
        t_cont(0, 1, 0, "R8 R4 step after wrap");
        t_desel(); t_desel();

        // R2: processor strobe with sel_a_n high is ignored, burst steps on
        t_ctl(4, 0, 1, 1, 4'hF, "R3 read");
        t_cont(0, 1, 0, "R2 ignored strobe steps", 0, 1);
        t_cont(1, 1, 0, "R4 hold");
        t_desel(); t_desel();

        // R1: disabled controller strobes write nothing
        t_ctl(4, 32'h99999999, 0, 1, 4'hF, "R1", 0, 0, 0);
        t_ctl(4, 32'h99999999, 0, 1, 4'hF, "R1", 0, 1, 1);
        t_ctl(4, 32'h99999999, 0, 1, 4'hF, "R1", 1, 1, 0);
        t_cont(0, 0, 32'h99999999, "R1 burst closed");
        t_desel();
        t_ctl(4, 0, 1, 1, 4'hF, "R1 word 4 unchanged");
        t_ctl(5, 0, 1, 1, 4'hF, "R1 word 5 unchanged");
        t_desel(); t_desel();

        // R11 R12: dummy reads with oe_n high still step
        t_ctl(12, 0, 1, 1, 4'hF, "R12 read");
        t_cont(0, 1, 0, "R12 step");
        oe_next = 1'b1;
        t_cont(0, 1, 0, "R11 R12 dummy step");
        t_cont(0, 1, 0, "R11 R12 dummy step");
        oe_next = 1'b0;
        t_cont(0, 1, 0, "R12 word after dummies");
        t_desel(); t_desel(); t_desel();

        // direct path
        pipe_sel = 1'b0; lat = 1;
        t_desel(); t_desel();
        t_ctl(4, 0, 1, 1, 4'hF, "R9 read");
        t_cont(0, 1, 0, "R9 step");
        t_desel();
        t_desel();
        t_desel();
        t_cpu(9, "R9 R2 read");
        t_cont(1, 1, 0, "R9 R4 hold");
        t_cont(0, 1, 0, "R9 R4 step");
        t_desel(); t_desel();

        // R7: read then write without deselect
        t_ctl(4, 0, 1, 1, 4'hF, "R9 read");
        t_ctl(6, 32'h66666666, 0, 1, 4'hF, "R7 read to write");
        t_desel(); t_desel();
        t_ctl(6, 0, 1, 1, 4'hF, "R7 R5 new word");
        t_desel(); t_desel(); t_desel();

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_up();
    end

endmodule